// File: doc/BRIEF.md
# USB Suspend Wake-Up Sequencer

This block governs how a USB peripheral controller comes back out of the suspend state. While the controller is suspended, the block watches for three kinds of wake event. The first is a K-state from the host on the bus. The second is a falling edge on an active-low wake pin. The third is a falling edge on the active-low chip-select, which counts only when a configuration bit allows it. Once an event is accepted, the block runs a fixed resume sequence. It turns the oscillator and PLL back on and waits for the clock-stable indication. It then opens the clock gate, drops the suspend indication and raises a resume interrupt flag. After the resume delay from the start of the wake, it declares normal operation again.

The resume delay is 5 ms, or 100 µs when the test input is high. When the wake came from the application side (pin or chip-select), the block also drives a K-state on the bus for 10 ms, starting when normal operation returns. When the host started the resume, the block only follows it. Register writes stay blocked from the moment of suspend entry until firmware issues an unlock command after the wake has finished. All intervals come from a single counter whose length is derived from the clock-frequency parameter.

Top module: `susp_wake_seq`

## Requirements
- R1: After reset the block is awake and in normal operation: osc_en, pll_en, clk_gate_en and normal_op are 1, and susp_ind, resume_flag, resume_irq, k_drive and wr_protect are 0.
- R2: A suspend_enter pulse sampled during normal operation makes the block suspended from the next cycle: osc_en, pll_en, clk_gate_en and normal_op go to 0, and susp_ind and wr_protect go to 1.
- R3: While suspended, the wake starts at the clock edge that samples bus_k_det high. A falling edge of wake_pin_n whose first low sample is at edge e starts the wake at edge e+2. A falling edge on cs_n behaves the same way, but only when cs_wake_en is 1; with cs_wake_en at 0, chip-select activity leaves osc_en at 0.
- R4: osc_en and pll_en are 1 from the wake start onward. clk_gate_en stays 0 and susp_ind stays 1 until clk_stable is sampled high.
- R5: At the first edge after the wake start that samples clk_stable high, clk_gate_en becomes 1, susp_ind becomes 0 and resume_flag becomes 1.
- R6: resume_irq is 1 exactly when resume_flag is 1 and resume_ie is 1.
- R7: resume_flag is cleared by resume_clr. When the flag is being set and resume_clr is high in the same cycle, the set wins.
- R8: normal_op rises exactly D cycles after the wake-start edge. D is CLK_FREQ_HZ/200 (5 ms) when test_short is 0, and CLK_FREQ_HZ/10000 (100 µs) when test_short is 1.
- R9: After an application wake, k_drive is 1 for CLK_FREQ_HZ/100 cycles (10 ms), starting on the edge where normal_op rises. After a host wake, k_drive stays 0. When a host K-state and an application event are accepted on the same edge, the wake is treated as a host wake.
- R10: wr_protect stays 1 after a wake until unlock_cmd is sampled while normal_op is 1. unlock_cmd sampled while suspended or waking has no effect.
- R11: suspend_enter is ignored while a wake sequence is in progress; susp_ind stays 0 and the sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| suspend_enter | input | 1 | Request to enter suspend (pulse) |
| bus_k_det | input | 1 | Host K-state detected on the bus (synchronous) |
| wake_pin_n | input | 1 | Active-low wake pin (asynchronous) |
| cs_n | input | 1 | Active-low chip-select (asynchronous) |
| cs_wake_en | input | 1 | Allow chip-select to wake the block |
| clk_stable | input | 1 | Oscillator and PLL are stable |
| test_short | input | 1 | Select the short 100 µs resume delay |
| resume_ie | input | 1 | Resume interrupt enable |
| resume_clr | input | 1 | Write-one-to-clear strobe for the resume flag |
| unlock_cmd | input | 1 | Register unlock command strobe |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_gate_en | output | 1 | Clock routed to the internal logic |
| susp_ind | output | 1 | Suspend indication pin, high while suspended |
| resume_flag | output | 1 | Resume interrupt status flag |
| resume_irq | output | 1 | Resume interrupt line |
| k_drive | output | 1 | Drive K-state on the bus |
| normal_op | output | 1 | Normal operation resumed |
| wr_protect | output | 1 | Register writes blocked |

## Verification
Setting the resume flag and clearing it from software can land in the same cycle. This happens when resume_clr is already held high at the edge where clk_stable is first sampled during a wake. The bench provokes the collision on a pin-started wake, with clk_stable already high, so the flag is set one cycle after the wake start. It expects the flag and the interrupt line to read 1 in that cycle and the flag to read 0 one cycle later, while resume_clr is still held. A second overlap, a host K-state and a pin edge accepted on the same edge, is judged by requiring k_drive to stay low after normal operation returns.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_SUSP   = 3'd1,
      ST_WAKE   = 3'd2,
      ST_RUN    = 3'd3,
      ST_KDRV   = 3'd4
   } wseq_state_e;

   typedef struct packed {
      logic host;
      logic app;
   } wake_src_t;

endpackage

// File: rtl/wake_edge_sync.sv
module wake_edge_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din_n,
   output logic [WIDTH-1:0] fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wake_edge_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("wake_edge_sync: WIDTH must be at least 1");
      end
   endgenerate

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES:0] chain_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q <= {chain_q[STAGES-1:0], din_n[b]};
            end
         end

         assign fall[b] = chain_q[STAGES] & ~chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wake_interval_timer.sv
module wake_interval_timer #(
   parameter int CLK_FREQ_HZ  = 48_000_000,
   parameter bit TEST_MODE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic test_short,
   output logic resume_due,
   output logic kdrive_done
);

   localparam int DLY_NORM = CLK_FREQ_HZ / 200;
   localparam int DLY_TEST = CLK_FREQ_HZ / 10_000;
   localparam int KDRV_LEN = CLK_FREQ_HZ / 100;
   localparam int CNT_MAX  = DLY_NORM + KDRV_LEN;
   localparam int CW       = $clog2(CNT_MAX + 1);

   localparam logic [CW-1:0] CNT_TOP   = CW'(CNT_MAX);
   localparam logic [CW-1:0] NORM_LAST = CW'(DLY_NORM - 1);
   localparam logic [CW-1:0] TEST_LAST = CW'(DLY_TEST - 1);
   localparam logic [CW-1:0] KDRV_C    = CW'(KDRV_LEN);

   generate
      if (DLY_TEST < 2) begin : g_bad_freq
         $error("wake_interval_timer: CLK_FREQ_HZ too small for the short delay");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] due_at;

   generate
      if (TEST_MODE_EN) begin : g_test_sel
         assign due_at = test_short ? TEST_LAST : NORM_LAST;
      end else begin : g_fixed
         logic unused_test;
         assign unused_test = test_short;
         assign due_at      = NORM_LAST;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (run && (cnt_q != CNT_TOP)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign resume_due  = (cnt_q >= due_at);
   assign kdrive_done = (cnt_q >= (due_at + KDRV_C));

   AST_DUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear && resume_due && $stable(test_short)) |=> resume_due); // R8

endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
   import wake_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        suspend_enter,
   input  wake_src_t   src,
   input  logic        clk_stable,
   input  logic        resume_due,
   input  logic        kdrive_done,
   output wseq_state_e state,
   output logic        tmr_clear,
   output logic        tmr_run,
   output logic        rsm_set,
   output logic        sus_entry
);

   wseq_state_e state_q, state_d;
   logic        remote_q, remote_d;
   logic        any_wake;

   assign any_wake = src.host | src.app;

   always_comb begin
      state_d  = state_q;
      remote_d = remote_q;
      unique case (state_q)
         ST_ACTIVE: if (suspend_enter) state_d = ST_SUSP;
         ST_SUSP: begin
            if (any_wake) begin
               state_d  = ST_WAKE;
               remote_d = src.app & ~src.host;
            end
         end
         ST_WAKE:   if (clk_stable) state_d = ST_RUN;
         ST_RUN:    if (resume_due) state_d = remote_q ? ST_KDRV : ST_ACTIVE;
         ST_KDRV:   if (kdrive_done) state_d = ST_ACTIVE;
         default:   state_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_ACTIVE;
         remote_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         remote_q <= remote_d;
      end
   end

   assign state     = state_q;
   assign tmr_clear = (state_q == ST_SUSP) && any_wake;
   assign tmr_run   = (state_q == ST_WAKE) || (state_q == ST_RUN) || (state_q == ST_KDRV);
   assign rsm_set   = (state_q == ST_WAKE) && clk_stable;
   assign sus_entry = (state_q == ST_ACTIVE) && suspend_enter;

   AST_HOST_NO_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SUSP) && src.host) |=> !remote_q); // R9

   AST_SUSPEND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RUN) && suspend_enter) |=> (state_q != ST_SUSP)); // R11

endmodule

// File: rtl/wake_status_regs.sv
module wake_status_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic rsm_set,
   input  logic resume_clr,
   input  logic resume_ie,
   input  logic sus_entry,
   input  logic unlock_cmd,
   input  logic normal_op,
   output logic resume_flag,
   output logic resume_irq,
   output logic wr_protect
);

   logic flag_q;
   logic wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (rsm_set) begin
         flag_q <= 1'b1;
      end else if (resume_clr) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= 1'b0;
      end else if (sus_entry) begin
         wp_q <= 1'b1;
      end else if (unlock_cmd && normal_op) begin
         wp_q <= 1'b0;
      end
   end

   assign resume_flag = flag_q;
   assign resume_irq  = flag_q & resume_ie;
   assign wr_protect  = wp_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rsm_set |=> flag_q); // R7

   AST_WP_ON_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
      sus_entry |=> wp_q); // R2

   AST_UNLOCK_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wp_q) |-> $past(unlock_cmd && normal_op)); // R10

endmodule

// File: rtl/susp_wake_seq.sv
module susp_wake_seq
   import wake_seq_pkg::*;
#(
   parameter int CLK_FREQ_HZ  = 48_000_000,
   parameter int SYNC_STAGES  = 2,
   parameter bit TEST_MODE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic suspend_enter,
   input  logic bus_k_det,
   input  logic wake_pin_n,
   input  logic cs_n,
   input  logic cs_wake_en,
   input  logic clk_stable,
   input  logic test_short,
   input  logic resume_ie,
   input  logic resume_clr,
   input  logic unlock_cmd,
   output logic osc_en,
   output logic pll_en,
   output logic clk_gate_en,
   output logic susp_ind,
   output logic resume_flag,
   output logic resume_irq,
   output logic k_drive,
   output logic normal_op,
   output logic wr_protect
);

   localparam int APP_PINS = 2;
   localparam int IDX_PIN  = 0;
   localparam int IDX_CS   = 1;

   logic [APP_PINS-1:0] pin_fall;
   wake_src_t           src;
   wseq_state_e         state;
   logic                tmr_clear, tmr_run, rsm_set, sus_entry;
   logic                resume_due, kdrive_done;

   wake_edge_sync #(
      .WIDTH  (APP_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din_n ({cs_n, wake_pin_n}),
      .fall  (pin_fall)
   );

   assign src.host = bus_k_det;
   assign src.app  = pin_fall[IDX_PIN] | (pin_fall[IDX_CS] & cs_wake_en);

   wake_seq_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .suspend_enter (suspend_enter),
      .src           (src),
      .clk_stable    (clk_stable),
      .resume_due    (resume_due),
      .kdrive_done   (kdrive_done),
      .state         (state),
      .tmr_clear     (tmr_clear),
      .tmr_run       (tmr_run),
      .rsm_set       (rsm_set),
      .sus_entry     (sus_entry)
   );

   wake_interval_timer #(
      .CLK_FREQ_HZ  (CLK_FREQ_HZ),
      .TEST_MODE_EN (TEST_MODE_EN)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (tmr_clear),
      .run         (tmr_run),
      .test_short  (test_short),
      .resume_due  (resume_due),
      .kdrive_done (kdrive_done)
   );

   assign osc_en      = (state != ST_SUSP);
   assign pll_en      = (state != ST_SUSP);
   assign clk_gate_en = (state == ST_RUN) || (state == ST_KDRV) || (state == ST_ACTIVE);
   assign susp_ind    = (state == ST_SUSP) || (state == ST_WAKE);
   assign normal_op   = (state == ST_KDRV) || (state == ST_ACTIVE);
   assign k_drive     = (state == ST_KDRV);

   wake_status_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .rsm_set     (rsm_set),
      .resume_clr  (resume_clr),
      .resume_ie   (resume_ie),
      .sus_entry   (sus_entry),
      .unlock_cmd  (unlock_cmd),
      .normal_op   (normal_op),
      .resume_flag (resume_flag),
      .resume_irq  (resume_irq),
      .wr_protect  (wr_protect)
   );

   AST_KDRV_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      k_drive |-> normal_op); // R9

   AST_CLK_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      clk_gate_en |-> (osc_en && pll_en)); // R4

   AST_FLAG_AT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(susp_ind) |-> resume_flag); // R5

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      resume_irq |-> resume_ie); // R6

   AST_SUSP_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp_ind) |-> wr_protect); // R2

endmodule

// File: tb/susp_wake_seq_test.sv
module susp_wake_seq_test;

   localparam int FREQ   = 200_000;
   localparam int D_NORM = FREQ / 200;
   localparam int D_TEST = FREQ / 10_000;
   localparam int K_LEN  = FREQ / 100;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic suspend_enter = 1'b0, bus_k_det = 1'b0, wake_pin_n = 1'b1, cs_n = 1'b1;
   logic cs_wake_en = 1'b0, clk_stable = 1'b1, test_short = 1'b0;
   logic resume_ie = 1'b0, resume_clr = 1'b0, unlock_cmd = 1'b0;
   logic osc_en, pll_en, clk_gate_en, susp_ind, resume_flag, resume_irq;
   logic k_drive, normal_op, wr_protect;

   susp_wake_seq #(.CLK_FREQ_HZ(FREQ)) uut (
      .clk(clk), .rst_n(rst_n), .suspend_enter(suspend_enter), .bus_k_det(bus_k_det),
      .wake_pin_n(wake_pin_n), .cs_n(cs_n), .cs_wake_en(cs_wake_en),
      .clk_stable(clk_stable), .test_short(test_short), .resume_ie(resume_ie),
      .resume_clr(resume_clr), .unlock_cmd(unlock_cmd), .osc_en(osc_en),
      .pll_en(pll_en), .clk_gate_en(clk_gate_en), .susp_ind(susp_ind),
      .resume_flag(resume_flag), .resume_irq(resume_irq), .k_drive(k_drive),
      .normal_op(normal_op), .wr_protect(wr_protect)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef enum int {S_OSC, S_PLL, S_CLK, S_SUSP, S_FLAG, S_IRQ, S_KDRV, S_NORM, S_WP} sig_e;
   typedef struct {
      int    c;
      sig_e  s;
      bit    v;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   function automatic logic probe(sig_e s);
      case (s)
         S_OSC:   return osc_en;
         S_PLL:   return pll_en;
         S_CLK:   return clk_gate_en;
         S_SUSP:  return susp_ind;
         S_FLAG:  return resume_flag;
         S_IRQ:   return resume_irq;
         S_KDRV:  return k_drive;
         S_NORM:  return normal_op;
         default: return wr_protect;
      endcase
   endfunction

   task automatic push(int c, sig_e s, bit v, string tag);
      exp_t e;
      e.c = c; e.s = s; e.v = v; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: pops every expectation due in this cycle and compares
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].c <= cyc) begin
            n_run++;
            if (sb[i].c < cyc) begin
               n_fail++;
               $display("FAIL %s: %s check at cycle %0d missed, actual x expected %0b",
                        sb[i].tag, sb[i].s.name(), sb[i].c, sb[i].v);
            end else if (probe(sb[i].s) !== sb[i].v) begin
               n_fail++;
               $display("FAIL %s: %s = %0b, expected %0b (cycle %0d)",
                        sb[i].tag, sb[i].s.name(), probe(sb[i].s), sb[i].v, cyc);
            end
            sb.delete(i);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic goto(int c);
      while (cyc < c) step();
   endtask

   task automatic enter_suspend();
      int n;
      n = cyc + 1;
      suspend_enter = 1'b1;
      push(n, S_SUSP, 1'b1, "R2");
      push(n, S_OSC,  1'b0, "R2");
      push(n, S_PLL,  1'b0, "R2");
      push(n, S_CLK,  1'b0, "R2");
      push(n, S_NORM, 1'b0, "R2");
      push(n, S_WP,   1'b1, "R2");
      step();
      suspend_enter = 1'b0;
      clk_stable    = 1'b0;
      step();
   endtask

   initial begin : main
      int p, w;
      repeat (4) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      w = cyc + 1;
      push(w, S_OSC, 1, "R1"); push(w, S_PLL, 1, "R1"); push(w, S_CLK, 1, "R1");
      push(w, S_NORM, 1, "R1"); push(w, S_SUSP, 0, "R1"); push(w, S_FLAG, 0, "R1");
      push(w, S_IRQ, 0, "R1"); push(w, S_KDRV, 0, "R1"); push(w, S_WP, 0, "R1");
      step(); step();

      // A: suspend
      enter_suspend();

      // B: chip-select with wake disabled, unlock while suspended
      p = cyc;
      cs_wake_en = 1'b0;
      cs_n = 1'b0;
      unlock_cmd = 1'b1;
      push(p + 3, S_OSC, 0, "R3");
      push(p + 6, S_OSC, 0, "R3");
      push(p + 3, S_WP,  1, "R10");
      step();
      unlock_cmd = 1'b0;
      step(); step();
      cs_n = 1'b1;
      goto(p + 8);

      // C: host wake, short delay, late clock-stable
      test_short = 1'b1;
      bus_k_det  = 1'b1;
      w = cyc + 1;
      push(w, S_OSC, 1, "R3"); push(w, S_PLL, 1, "R4");
      push(w, S_CLK, 0, "R4"); push(w, S_SUSP, 1, "R4");
      push(w + 3, S_CLK, 0, "R4"); push(w + 4, S_FLAG, 0, "R5");
      push(w + 5, S_CLK, 1, "R5"); push(w + 5, S_SUSP, 0, "R5");
      push(w + 5, S_FLAG, 1, "R5"); push(w + 5, S_IRQ, 0, "R6");
      push(w + 9, S_SUSP, 0, "R11"); push(w + 9, S_CLK, 1, "R11");
      push(w + D_TEST - 1, S_NORM, 0, "R8"); push(w + D_TEST, S_NORM, 1, "R8");
      push(w + D_TEST, S_KDRV, 0, "R9"); push(w + D_TEST + 5, S_KDRV, 0, "R9");
      push(w + D_TEST + 5, S_WP, 1, "R10");
      step();
      bus_k_det = 1'b0;
      goto(w + 4);
      clk_stable = 1'b1;
      goto(w + 8);
      suspend_enter = 1'b1;
      step();
      suspend_enter = 1'b0;
      goto(w + D_TEST + 6);
      resume_ie = 1'b1;
      push(cyc, S_IRQ, 1, "R6");
      unlock_cmd = 1'b1;
      push(cyc + 1, S_WP, 0, "R10");
      step();
      unlock_cmd = 1'b0;
      resume_clr = 1'b1;
      push(cyc + 1, S_FLAG, 0, "R7");
      push(cyc + 1, S_IRQ,  0, "R6");
      step();
      resume_clr = 1'b0;
      step();

      // D: pin wake, long delay, set and clear collide
      enter_suspend();
      test_short = 1'b0;
      p = cyc;
      wake_pin_n = 1'b0;
      clk_stable = 1'b1;
      resume_clr = 1'b1;
      w = p + 3;
      push(p + 2, S_OSC, 0, "R3"); push(w, S_OSC, 1, "R3");
      push(w + 1, S_FLAG, 1, "R7"); push(w + 1, S_IRQ, 1, "R6");
      push(w + 1, S_CLK, 1, "R5"); push(w + 2, S_FLAG, 0, "R7");
      push(w + D_NORM - 1, S_NORM, 0, "R8"); push(w + D_NORM, S_NORM, 1, "R8");
      push(w + D_NORM - 1, S_KDRV, 0, "R9"); push(w + D_NORM, S_KDRV, 1, "R9");
      push(w + D_NORM + K_LEN - 1, S_KDRV, 1, "R9");
      push(w + D_NORM + K_LEN, S_KDRV, 0, "R9");
      push(w + D_NORM + 500, S_WP, 1, "R10");
      goto(w);
      wake_pin_n = 1'b1;
      goto(w + 2);
      resume_clr = 1'b0;
      goto(w + D_NORM + K_LEN + 2);
      unlock_cmd = 1'b1;
      step();
      unlock_cmd = 1'b0;

      // E: chip-select wake enabled, short delay
      enter_suspend();
      test_short = 1'b1;
      cs_wake_en = 1'b1;
      p = cyc;
      cs_n = 1'b0;
      clk_stable = 1'b1;
      w = p + 3;
      push(w - 1, S_OSC, 0, "R3"); push(w, S_OSC, 1, "R3");
      push(w + D_TEST, S_NORM, 1, "R8");
      push(w + D_TEST, S_KDRV, 1, "R9");
      push(w + D_TEST + K_LEN - 1, S_KDRV, 1, "R9");
      push(w + D_TEST + K_LEN, S_KDRV, 0, "R9");
      step(); step();
      cs_n = 1'b1;
      goto(w + D_TEST + K_LEN + 2);

      // F: host K-state and pin edge accepted together
      enter_suspend();
      p = cyc;
      wake_pin_n = 1'b0;
      clk_stable = 1'b1;
      w = p + 3;
      push(w, S_OSC, 1, "R3");
      push(w + D_TEST, S_NORM, 1, "R8");
      push(w + D_TEST, S_KDRV, 0, "R9");
      push(w + D_TEST + 1, S_KDRV, 0, "R9");
      goto(p + 2);
      bus_k_det = 1'b1;
      step();
      bus_k_det = 1'b0;
      wake_pin_n = 1'b1;
      goto(w + D_TEST + 4);

      step(); step();
      while (sb.size() > 0) begin
         n_run++;
         n_fail++;
         $display("FAIL %s: %s check at cycle %0d never sampled, actual x expected %0b",
                  sb[0].tag, sb[0].s.name(), sb[0].c, sb[0].v);
         sb.delete(0);
      end
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : watchdog
      #(4 * 100_000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog (all requirements): run not finished, actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule